// File: doc/BRIEF.md
# Memory Type Range Register Bank

This block holds the configuration that classifies physical memory by caching behaviour. It contains a default-type register with two enable bits, eleven fixed-range registers of eight packed type bytes each, a page attribute register of eight packed attribute bytes, and a parameterised number of variable ranges, each made of a base register and a mask register. One request port addresses them by a 12-bit register address and either writes a 64-bit value or reads one back.

Each write is screened before it lands. Every type byte must carry a legal encoding, and reserved bits must be clear. The reserved set of a variable range depends on the physical address width parameter. A rejected write changes nothing and produces a one-cycle fault pulse. Reads and writes to addresses the bank does not know are refused in the same way. All stored state is also driven out continuously in decoded form, so that a separate resolver can look up addresses without using the register port.

Top module: `mtr_bank`

## Requirements
- R1: While reset is asserted and after it is released, every stored value is zero. Both enables read 0, the default type is 0, and the page attribute, fixed-range and variable outputs are all zero.
- R2: A memory-type byte is legal only when its value is 0, 1, 4, 5 or 6. An attribute byte is legal for those same values and also for 7. The values 2, 3 and 8 to 255 are illegal in both.
- R3: The default-type register is at address 0x2FF. A write is rejected if any bit outside 0xCFF is set, or if bits 7:0 are not a legal memory type. An accepted write stores bits 7:0 as `def_type`, bit 11 as `glob_en` and bit 10 as `fix_en`. A read returns `glob_en` in bit 11, `fix_en` in bit 10 and the type in bits 7:0, with every other bit zero.
- R4: The bank has eleven fixed-range registers. Address 0x250 is slot 0 and covers 64 KB granules. Addresses 0x258 and 0x259 are slots 1 and 2 and cover 16 KB granules. Addresses 0x268 to 0x26F are slots 3 to 10 and cover 4 KB granules. All eight bytes of a written value must be legal memory types. Slot k is driven on `fix_types[64k+63:64k]`.
- R5: The page attribute register is at address 0x277. A write is accepted only when all eight bytes are legal attribute types, and it is driven on `pat_value`.
- R6: The base of variable pair i is at address 0x200+2i. A base write is rejected if bits 7:0 are not a legal memory type, if any of bits 11:8 is set, or if any bit at or above PA_W is set. Pair i is driven on `var_base[64i+63:64i]`.
- R7: The mask of variable pair i is at address 0x201+2i. A mask write is rejected if any of bits 10:0 is set or if any bit at or above PA_W is set. Bit 11, the range-valid flag, is stored. Pair i is driven on `var_mask[64i+63:64i]`.
- R8: A rejected write leaves all stored state unchanged. `fault` is high for exactly the one cycle that follows the request.
- R9: A read or write to an address outside the known set raises the same fault pulse. It gives no read response and changes no state.
- R10: Address 0x2F8 is a known address with no storage. A write to it never faults and has no effect. A read from it returns zero.
- R11: An accepted read raises `rsp_valid` for the one cycle after the request, with `rsp_rdata` holding the stored value.
- R12: An accepted write is visible on the decoded outputs in the cycle after the clock edge that samples the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register address |
| req_wdata | input | 64 | Write value |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 64 | Read response value |
| fault | output | 1 | One-cycle pulse for a refused request |
| glob_en | output | 1 | Global enable |
| fix_en | output | 1 | Fixed-range enable |
| def_type | output | 8 | Default memory type |
| fix_types | output | 11*64 | Fixed-range type bytes, slot k at 64k |
| pat_value | output | 64 | Page attribute bytes |
| var_base | output | NUM_VAR*64 | Variable bases, pair i at 64i |
| var_mask | output | NUM_VAR*64 | Variable masks, pair i at 64i |

## Verification
Every stored register drives a decoded output directly. A wrong write, a missing write or a corrupted slot therefore shows on `def_type`, `fix_types`, `pat_value`, `var_base` or `var_mask` in the very next cycle, and the per-cycle comparison catches it there. A legality error shows up in two places in the same cycle: `fault` takes the wrong value, and a value that should have been refused appears in the stored fields. A wrong address decode shows up either as a write landing in the wrong slot or, one cycle after a read, as the wrong `rsp_rdata`.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 64;
  localparam int FIX_REGS = 11;

  typedef enum logic [2:0] {
    RC_NONE, RC_DEF, RC_PAT, RC_FIX, RC_VBASE, RC_VMASK, RC_SPARE
  } reg_class_e;

  localparam logic [ADDR_W-1:0] A_VAR0  = 12'h200;
  localparam logic [ADDR_W-1:0] A_FIX64 = 12'h250;
  localparam logic [ADDR_W-1:0] A_FIX16 = 12'h258;
  localparam logic [ADDR_W-1:0] A_FIX4  = 12'h268;
  localparam logic [ADDR_W-1:0] A_PAT   = 12'h277;
  localparam logic [ADDR_W-1:0] A_SPARE = 12'h2F8;
  localparam logic [ADDR_W-1:0] A_DEF   = 12'h2FF;

  localparam logic [DATA_W-1:0] DEF_KEEP = 64'hCFF;

  // Caching-type encodings legal in range registers.
  function automatic logic mem_type_ok(input logic [7:0] t);
    return t inside {8'd0, 8'd1, 8'd4, 8'd5, 8'd6};
  endfunction

  // Attribute encodings: range types plus 7.
  function automatic logic attr_type_ok(input logic [7:0] t);
    return mem_type_ok(t) || (t == 8'd7);
  endfunction

  function automatic logic all_mem_bytes(input logic [DATA_W-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < DATA_W/8; b++)
      if (!mem_type_ok(d[8*b +: 8])) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic all_attr_bytes(input logic [DATA_W-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < DATA_W/8; b++)
      if (!attr_type_ok(d[8*b +: 8])) ok = 1'b0;
    return ok;
  endfunction

  // Bits at and above the physical address width.
  function automatic logic [DATA_W-1:0] above_pa(input int paw);
    return (paw >= DATA_W) ? '0 : (~64'd0 << paw);
  endfunction

endpackage

// File: rtl/mtr_addr_decode.sv
module mtr_addr_decode
  import mtr_pkg::*;
#(
  parameter int NUM_VAR = 8,
  parameter int VIDX_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_class_e        cls,
  output logic [3:0]        fix_idx,
  output logic [VIDX_W-1:0] var_idx
);

  localparam logic [ADDR_W-1:0] VAR_SPAN = ADDR_W'(2 * NUM_VAR);

  logic [ADDR_W-1:0] var_off;
  logic [ADDR_W-1:0] fix4_off;
  logic              in_var;

  assign var_off  = addr - A_VAR0;
  assign fix4_off = addr - A_FIX4;
  assign in_var   = (addr >= A_VAR0) && (var_off < VAR_SPAN);

  always_comb begin
    cls     = RC_NONE;
    fix_idx = '0;
    var_idx = VIDX_W'(var_off >> 1);
    if (addr == A_DEF)                           cls = RC_DEF;
    else if (addr == A_PAT)                      cls = RC_PAT;
    else if (addr == A_SPARE)                    cls = RC_SPARE;
    else if (addr == A_FIX64) begin              cls = RC_FIX; fix_idx = 4'd0; end
    else if (addr == A_FIX16) begin              cls = RC_FIX; fix_idx = 4'd1; end
    else if (addr == A_FIX16 + 12'd1) begin      cls = RC_FIX; fix_idx = 4'd2; end
    else if (addr >= A_FIX4 && fix4_off < 12'd8) begin
      cls     = RC_FIX;
      fix_idx = 4'(fix4_off) + 4'd3;
    end
    else if (in_var)                             cls = var_off[0] ? RC_VMASK : RC_VBASE;
  end

endmodule

// File: rtl/mtr_write_check.sv
module mtr_write_check
  import mtr_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  reg_class_e        cls,
  input  logic [DATA_W-1:0] wdata,
  output logic              legal
);

  localparam logic [DATA_W-1:0] HI_MASK = above_pa(PA_W);

  logic high_clear;
  assign high_clear = (wdata & HI_MASK) == '0;

  always_comb begin
    unique case (cls)
      RC_DEF:   legal = ((wdata & ~DEF_KEEP) == '0) && mem_type_ok(wdata[7:0]);
      RC_PAT:   legal = all_attr_bytes(wdata);
      RC_FIX:   legal = all_mem_bytes(wdata);
      RC_VBASE: legal = mem_type_ok(wdata[7:0]) && (wdata[11:8] == 4'd0) && high_clear;
      RC_VMASK: legal = (wdata[10:0] == 11'd0) && high_clear;
      RC_SPARE: legal = 1'b1;
      default:  legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/mtr_store.sv
module mtr_store
  import mtr_pkg::*;
#(
  parameter int NUM_VAR = 8,
  parameter int PA_W    = 36,
  parameter int VIDX_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit,
  input  reg_class_e                  cls,
  input  logic [3:0]                  fix_idx,
  input  logic [VIDX_W-1:0]           var_idx,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rd_value,
  output logic                        glob_en,
  output logic                        fix_en,
  output logic [7:0]                  def_type,
  output logic [FIX_REGS*DATA_W-1:0]  fix_flat,
  output logic [DATA_W-1:0]           pat,
  output logic [NUM_VAR*DATA_W-1:0]   vb_flat,
  output logic [NUM_VAR*DATA_W-1:0]   vm_flat
);

  localparam logic [DATA_W-1:0] HI_MASK = above_pa(PA_W);

  logic [DATA_W-1:0] fix_q [FIX_REGS];
  logic [DATA_W-1:0] vb_q  [NUM_VAR];
  logic [DATA_W-1:0] vm_q  [NUM_VAR];
  logic [DATA_W-1:0] pat_q;
  logic [7:0]        def_q;
  logic              ge_q, fe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < FIX_REGS; k++) fix_q[k] <= '0;
      for (int i = 0; i < NUM_VAR; i++) begin
        vb_q[i] <= '0;
        vm_q[i] <= '0;
      end
      pat_q <= '0;
      def_q <= '0;
      ge_q  <= 1'b0;
      fe_q  <= 1'b0;
    end else if (commit) begin
      unique case (cls)
        RC_DEF: begin
          def_q <= wdata[7:0];
          ge_q  <= wdata[11];
          fe_q  <= wdata[10];
        end
        RC_PAT:   pat_q            <= wdata;
        RC_FIX:   fix_q[fix_idx]   <= wdata;
        RC_VBASE: vb_q[var_idx]    <= wdata;
        RC_VMASK: vm_q[var_idx]    <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (cls)
      RC_DEF:   rd_value = {52'd0, ge_q, fe_q, 2'b00, def_q};
      RC_PAT:   rd_value = pat_q;
      RC_FIX:   rd_value = fix_q[fix_idx];
      RC_VBASE: rd_value = vb_q[var_idx];
      RC_VMASK: rd_value = vm_q[var_idx];
      default:  rd_value = '0;
    endcase
  end

  assign glob_en  = ge_q;
  assign fix_en   = fe_q;
  assign def_type = def_q;
  assign pat      = pat_q;

  for (genvar k = 0; k < FIX_REGS; k++) begin : g_fix
    assign fix_flat[k*DATA_W +: DATA_W] = fix_q[k];
    a_r4_fix_bytes_legal: assert property (@(posedge clk) disable iff (!rst_n)
      all_mem_bytes(fix_q[k]));
  end

  for (genvar i = 0; i < NUM_VAR; i++) begin : g_var
    assign vb_flat[i*DATA_W +: DATA_W] = vb_q[i];
    assign vm_flat[i*DATA_W +: DATA_W] = vm_q[i];
    a_r6_base_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (vb_q[i][11:8] == 4'd0) && ((vb_q[i] & HI_MASK) == '0) && mem_type_ok(vb_q[i][7:0]));
    a_r7_mask_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (vm_q[i][10:0] == 11'd0) && ((vm_q[i] & HI_MASK) == '0));
  end

  a_r3_default_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_type_ok(def_q));
  a_r5_attr_bytes_legal: assert property (@(posedge clk) disable iff (!rst_n)
    all_attr_bytes(pat_q));

endmodule

// File: rtl/mtr_bank.sv
module mtr_bank
  import mtr_pkg::*;
#(
  parameter int NUM_VAR = 8,
  parameter int PA_W    = 36
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  input  logic                               req_write,
  input  logic [11:0]                        req_addr,
  input  logic [63:0]                        req_wdata,
  output logic                               rsp_valid,
  output logic [63:0]                        rsp_rdata,
  output logic                               fault,
  output logic                               glob_en,
  output logic                               fix_en,
  output logic [7:0]                         def_type,
  output logic [mtr_pkg::FIX_REGS*64-1:0]    fix_types,
  output logic [63:0]                        pat_value,
  output logic [NUM_VAR*64-1:0]              var_base,
  output logic [NUM_VAR*64-1:0]              var_mask
);

  localparam int VIDX_W = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;

  reg_class_e          cls;
  logic [3:0]          fix_idx;
  logic [VIDX_W-1:0]   var_idx;
  logic                wr_legal;
  logic                addr_known;
  logic [DATA_W-1:0]   rd_value;

  // Named request outcomes.
  logic wr_accept, wr_reject, rd_accept, rd_reject;

  mtr_addr_decode #(.NUM_VAR(NUM_VAR), .VIDX_W(VIDX_W)) u_dec (
    .addr    (req_addr),
    .cls     (cls),
    .fix_idx (fix_idx),
    .var_idx (var_idx)
  );

  mtr_write_check #(.PA_W(PA_W)) u_chk (
    .cls   (cls),
    .wdata (req_wdata),
    .legal (wr_legal)
  );

  assign addr_known = (cls != RC_NONE);
  assign wr_accept  = req_valid &&  req_write && addr_known && wr_legal;
  assign wr_reject  = req_valid &&  req_write && !(addr_known && wr_legal);
  assign rd_accept  = req_valid && !req_write && addr_known;
  assign rd_reject  = req_valid && !req_write && !addr_known;

  mtr_store #(.NUM_VAR(NUM_VAR), .PA_W(PA_W), .VIDX_W(VIDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (wr_accept),
    .cls      (cls),
    .fix_idx  (fix_idx),
    .var_idx  (var_idx),
    .wdata    (req_wdata),
    .rd_value (rd_value),
    .glob_en  (glob_en),
    .fix_en   (fix_en),
    .def_type (def_type),
    .fix_flat (fix_types),
    .pat      (pat_value),
    .vb_flat  (var_base),
    .vm_flat  (var_mask)
  );

  logic              fault_q, rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      fault_q     <= wr_reject || rd_reject;
      rsp_valid_q <= rd_accept;
      if (rd_accept) rsp_rdata_q <= rd_value;
    end
  end

  assign fault     = fault_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // R8: a refused request leaves every stored field as it was.
  a_r8_reject_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($stable(pat_value) && $stable(def_type) && $stable(glob_en) && $stable(fix_en)
               && $stable(fix_types) && $stable(var_base) && $stable(var_mask)));
  a_r8_fault_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(req_valid));
  a_r9_no_response_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && rsp_valid));
  a_r11_response_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  a_r12_attr_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && cls == RC_PAT) |=> (pat_value == $past(req_wdata)));

endmodule

// File: tb/tb_mtr_bank.sv
`timescale 1ns/1ps
module tb_mtr_bank;

  localparam int NV   = 8;
  localparam int PA   = 36;
  localparam int NFIX = 11;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0, req_write = 1'b0;
  logic [11:0]        req_addr = '0;
  logic [63:0]        req_wdata = '0;
  logic               rsp_valid, fault, glob_en, fix_en;
  logic [63:0]        rsp_rdata, pat_value;
  logic [7:0]         def_type;
  logic [NFIX*64-1:0] fix_types;
  logic [NV*64-1:0]   var_base, var_mask;

  mtr_bank #(.NUM_VAR(NV), .PA_W(PA)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .fault(fault), .glob_en(glob_en), .fix_en(fix_en),
    .def_type(def_type), .fix_types(fix_types), .pat_value(pat_value),
    .var_base(var_base), .var_mask(var_mask)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [63:0] m_fix [NFIX];
  logic [63:0] m_vb  [NV];
  logic [63:0] m_vm  [NV];
  logic [63:0] m_pat;
  logic [7:0]  m_def;
  logic        m_ge, m_fe;
  logic        e_fault, e_rv;
  logic [63:0] e_rd;

  function automatic bit mem_ok(int v);
    return v == 0 || v == 1 || v == 4 || v == 5 || v == 6;
  endfunction

  // 0 unknown, 1 default, 2 attribute, 3 fixed, 4 base, 5 mask, 6 spare
  function automatic int kind_of(logic [11:0] a);
    if (a == 12'h2FF) return 1;
    if (a == 12'h277) return 2;
    if (a == 12'h250 || a == 12'h258 || a == 12'h259 || (a >= 12'h268 && a <= 12'h26F)) return 3;
    if (a == 12'h2F8) return 6;
    if (int'(a) >= 'h200 && int'(a) < 'h200 + 2*NV) return a[0] ? 5 : 4;
    return 0;
  endfunction

  function automatic int fix_slot(logic [11:0] a);
    if (a == 12'h250) return 0;
    if (a == 12'h258) return 1;
    if (a == 12'h259) return 2;
    return 3 + int'(a) - 'h268;
  endfunction

  function automatic bit write_ok(int k, logic [63:0] d);
    bit ok = 1;
    case (k)
      1: ok = ((d & ~64'hCFF) == 0) && mem_ok(int'(d[7:0]));
      2: for (int b = 0; b < 8; b++) if (int'(d[8*b +: 8]) > 7 || d[8*b +: 8] == 2 || d[8*b +: 8] == 3) ok = 0;
      3: for (int b = 0; b < 8; b++) if (!mem_ok(int'(d[8*b +: 8]))) ok = 0;
      4: ok = mem_ok(int'(d[7:0])) && (((d >> 8) & 64'hF) == 0) && ((d >> PA) == 0);
      5: ok = ((d & 64'h7FF) == 0) && ((d >> PA) == 0);
      6: ok = 1;
      default: ok = 0;
    endcase
    return ok;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NFIX; k++) m_fix[k] = '0;
      for (int i = 0; i < NV; i++) begin m_vb[i] = '0; m_vm[i] = '0; end
      m_pat = '0; m_def = '0; m_ge = 0; m_fe = 0;
      e_fault = 0; e_rv = 0; e_rd = '0;
    end else begin
      int  k;
      bit  ok;
      int  p;
      k  = kind_of(req_addr);
      ok = (k != 0) && (!req_write || write_ok(k, req_wdata));
      p  = (int'(req_addr) - 'h200) / 2;
      e_fault = req_valid && !ok;
      e_rv    = req_valid && ok && !req_write;
      if (e_rv) begin
        case (k)
          1: e_rd = {52'd0, m_ge, m_fe, 2'b00, m_def};
          2: e_rd = m_pat;
          3: e_rd = m_fix[fix_slot(req_addr)];
          4: e_rd = m_vb[p];
          5: e_rd = m_vm[p];
          default: e_rd = '0;
        endcase
      end
      if (req_valid && ok && req_write) begin
        case (k)
          1: begin m_def = req_wdata[7:0]; m_ge = req_wdata[11]; m_fe = req_wdata[10]; end
          2: m_pat = req_wdata;
          3: m_fix[fix_slot(req_addr)] = req_wdata;
          4: m_vb[p] = req_wdata;
          5: m_vm[p] = req_wdata;
          default: ;
        endcase
      end
    end
  end

  bit run = 0;
  always @(negedge clk) begin
    if (rst_n && run) begin
      check("R8 fault", {63'd0, fault}, {63'd0, e_fault});
      check("R11 rsp_valid", {63'd0, rsp_valid}, {63'd0, e_rv});
      if (e_rv) check("R11 rsp_rdata", rsp_rdata, e_rd);
      check("R3 enables/type", {54'd0, glob_en, fix_en, def_type}, {54'd0, m_ge, m_fe, m_def});
      check("R5 attribute", pat_value, m_pat);
      for (int k = 0; k < NFIX; k++) check("R4 fixed slot", fix_types[k*64 +: 64], m_fix[k]);
      for (int i = 0; i < NV; i++) begin
        check("R6 base", var_base[i*64 +: 64], m_vb[i]);
        check("R7 mask", var_mask[i*64 +: 64], m_vm[i]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(input logic w, input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  function automatic logic [11:0] pick_addr();
    int r = $urandom_range(0, 31);
    if (r < 16)  return 12'(12'h200 + r);
    if (r == 16) return 12'h210;
    if (r == 17) return 12'h250;
    if (r == 18) return 12'h258;
    if (r == 19) return 12'h259;
    if (r < 28)  return 12'(12'h268 + r - 20);
    if (r == 28) return 12'h277;
    if (r == 29) return 12'h2F8;
    if (r == 30) return 12'h2FF;
    return 12'h251;
  endfunction

  function automatic logic [63:0] pick_data(logic [11:0] a);
    logic [63:0] d;
    int m = $urandom_range(0, 3);
    d = {$urandom(), $urandom()};
    if (m == 0) begin
      for (int b = 0; b < 8; b++) d[8*b +: 8] = 8'($urandom_range(0, 8));
    end else if (m >= 2) begin
      case (kind_of(a))
        1: begin d = d & 64'hC00; d[7:0] = 8'($urandom_range(0, 6)); end
        4: begin d = d & ((64'd1 << PA) - 1) & ~64'hFFF; d[7:0] = 8'($urandom_range(0, 6)); end
        5: d = d & ((64'd1 << PA) - 1) & ~64'h7FF;
        default: for (int b = 0; b < 8; b++) d[8*b +: 8] = 8'($urandom_range(4, 7));
      endcase
    end
    return d;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 glob_en", {63'd0, glob_en}, 64'd0);
    check("R1 fix_en", {63'd0, fix_en}, 64'd0);
    check("R1 def_type", {56'd0, def_type}, 64'd0);
    check("R1 pat", pat_value, 64'd0);
    check("R1 fixed", {63'd0, |fix_types}, 64'd0);
    check("R1 variable", {63'd0, |{var_base, var_mask}}, 64'd0);
    rst_n = 1'b1;
    run = 1;

    // R3 default-type register
    op(1, 12'h2FF, 64'hC06);
    check("R3 glob_en", {63'd0, glob_en}, 64'd1);
    check("R3 fix_en", {63'd0, fix_en}, 64'd1);
    check("R3 def_type", {56'd0, def_type}, 64'd6);
    op(0, 12'h2FF, 0);
    check("R3 readback", rsp_rdata, 64'hC06);
    op(1, 12'h2FF, 64'h106);
    check("R3 bit8 rejected", {63'd0, fault}, 64'd1);
    // R2 illegal type 2 and 3
    op(1, 12'h2FF, 64'h002);
    check("R2 type 2 rejected", {63'd0, fault}, 64'd1);
    check("R8 state kept", {56'd0, def_type}, 64'd6);
    op(1, 12'h2FF, 64'h003);
    check("R2 type 3 rejected", {63'd0, fault}, 64'd1);

    // R5 attribute register, R12 visibility
    op(1, 12'h277, 64'h0706_0504_0100_0007);
    check("R12 attr visible", pat_value, 64'h0706_0504_0100_0007);
    check("R2 type 7 ok in attribute", {63'd0, fault}, 64'd0);
    op(1, 12'h277, 64'h0003_0000_0000_0000);
    check("R5 bad byte rejected", {63'd0, fault}, 64'd1);
    check("R8 attr kept", pat_value, 64'h0706_0504_0100_0007);

    // R4 fixed range
    op(1, 12'h26F, 64'h0606_0505_0404_0100);
    check("R4 slot10", fix_types[10*64 +: 64], 64'h0606_0505_0404_0100);
    op(1, 12'h250, 64'h0000_0007_0000_0000);
    check("R2 type 7 illegal in fixed", {63'd0, fault}, 64'd1);
    op(1, 12'h259, 64'h0000_0000_0000_0008);
    check("R4 type 8 rejected", {63'd0, fault}, 64'd1);

    // R6 / R7 variable pair 1
    op(1, 12'h202, 64'h0000_000F_FFFF_F006);
    check("R6 base stored", var_base[64 +: 64], 64'h0000_000F_FFFF_F006);
    op(1, 12'h202, 64'h0000_0010_0000_0006);
    check("R6 bit36 rejected", {63'd0, fault}, 64'd1);
    op(1, 12'h202, 64'h0000_0000_0000_0206);
    check("R6 bit9 rejected", {63'd0, fault}, 64'd1);
    op(1, 12'h203, 64'h0000_000F_FFFF_F800);
    check("R7 mask stored", var_mask[64 +: 64], 64'h0000_000F_FFFF_F800);
    op(1, 12'h203, 64'h0000_0000_0000_0801);
    check("R7 bit0 rejected", {63'd0, fault}, 64'd1);

    // R9 unknown addresses
    op(1, 12'h251, 64'h0);
    check("R9 write unknown", {63'd0, fault}, 64'd1);
    op(0, 12'h300, 64'h0);
    check("R9 read unknown fault", {63'd0, fault}, 64'd1);
    check("R9 read unknown no rsp", {63'd0, rsp_valid}, 64'd0);

    // R10 spare address
    op(1, 12'h2F8, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R10 spare write", {63'd0, fault}, 64'd0);
    op(0, 12'h2F8, 64'h0);
    check("R10 spare read valid", {63'd0, rsp_valid}, 64'd1);
    check("R10 spare read zero", rsp_rdata, 64'd0);

    // R11 read of stored base
    op(0, 12'h202, 64'h0);
    check("R11 base readback", rsp_rdata, 64'h0000_000F_FFFF_F006);

    // mixed traffic against the model
    for (int n = 0; n < 1500; n++) begin
      logic [11:0] a;
      a = pick_addr();
      op(1'($urandom_range(0, 1)), a, pick_data(a));
    end

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule